// File: doc/BRIEF.md
# Bus Data-Phase Responder with Early Termination

This block answers the data phase of a split-transaction processor bus from the memory side. Requests arrive on a valid/ready stream and wait in an in-order queue. Each request is a read or a write to a small internal register file. It is either one beat or a four-beat line burst on a 64-bit data bus. For every beat the block raises a data strobe, `dvalid`. The word that belongs to that beat is exchanged on the data bus exactly two clock cycles later. Read data is driven on `rd_data` and `rd_chk`. Write data is sampled from `bus_wr_data`.

A request can ask for an early end on a chosen beat. The usual reason is a decode error found upstream. On that beat the block raises `abort` together with `dvalid` and drops the rest of the burst. It then keeps the strobe low for one cycle, which leaves the data bus idle. Two cycles after an aborted read beat, the block still drives the data and check-bit buses, both to all zeros. Two cycles after an aborted write beat, it samples nothing. A one-cycle `done` pulse marks the data slot of the beat that ended each transaction. `done_aborted` shows whether that end was an abort.

Request stream rules: a request moves when `req_valid` and `req_ready` are both high at a rising edge. `req_ready` falls only when the queue is full. A source that sees it low holds its request fields stable until the transfer happens. The bus side has no back-pressure, because its timing is fixed by the strobe.

Top module: `bus_beat_responder`

## Requirements
- R1: While reset is held, and in the first cycle after it, `dvalid`, `abort`, `rd_drive`, `done` and `done_aborted` are low, `req_ready` is high, and every register reads back as zero.
- R2: A single request (`req_burst`=0) produces one `dvalid` cycle. A burst request (`req_burst`=1) produces four `dvalid` cycles in a row, and beat k addresses register (`req_addr`+k) modulo the register count.
- R3: For a read beat that is not aborted, `rd_drive` is high exactly two cycles after its `dvalid` cycle, and `rd_data` carries the addressed register in that cycle. `rd_chk` bit j is then the XOR of `rd_data` bits 8j+7..8j. In every cycle with `rd_drive` low, `rd_data` and `rd_chk` are zero.
- R4: For a write beat that is not aborted, `bus_wr_data` is written to the addressed register at the clock edge that ends the cycle two cycles after its `dvalid`, and `rd_drive` stays low in that cycle.
- R5: `abort` is high only together with `dvalid`. It rises on beat min(`req_abort_beat`, last beat) when `req_abort_en` is set, where the last beat is 3 for a burst and 0 for a single request. It never rises when `req_abort_en` is clear.
- R6: No beat of an aborted transaction follows its abort beat. The next `dvalid` belongs to the next queued request.
- R7: In the cycle after `abort` is high, both `dvalid` and `abort` are low.
- R8: Two cycles after an aborted read beat, `rd_drive` is high and `rd_data` and `rd_chk` are all zeros.
- R9: Two cycles after an aborted write beat, no register changes and `rd_drive` stays low. Beats before the abort beat transfer normally.
- R10: Requests are served in acceptance order. `req_ready` is low exactly when DEPTH requests are waiting. When no abort intervenes, the first beat of the next queued request follows the last beat of the current one with no gap.
- R11: `done` pulses for exactly one cycle per transaction, in the data slot two cycles after its final or aborting beat. `done_aborted` is high in that cycle only if the transaction was aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered on the stream |
| req_ready | output | 1 | Queue can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-beat burst, 0 = single beat |
| req_addr | input | ADDR_W (4) | Starting register index |
| req_abort_en | input | 1 | End this transaction early |
| req_abort_beat | input | BEAT_W (2) | Beat on which to abort, clipped to the last beat |
| dvalid | output | 1 | Data-beat strobe |
| abort | output | 1 | Early termination on the current beat |
| bus_wr_data | input | DATA_W (64) | Write data from the bus |
| rd_drive | output | 1 | Read-data slot is being driven |
| rd_data | output | DATA_W (64) | Read data |
| rd_chk | output | DATA_W/8 (8) | Per-byte check bits |
| done | output | 1 | Transaction ended in this data slot |
| done_aborted | output | 1 | The ending transaction was aborted |

## Verification
A sequencer that loses its beat count shows up on `dvalid` within one cycle, as a beat too many or too few, or as a strobe in the idle cycle after `abort`. A wrong next-address or queue pointer stays hidden until the affected word is read, so read-back passes after write bursts and after aborted writes bring it to `rd_data` some cycles later. A data pipeline slipped by one stage moves `rd_drive`, `done` or the sampled write word by one cycle, and the per-cycle comparison against the reference model flags that at once. A dropped write-suppress flag is also seen only at the next read of the clobbered register.

// File: rtl/bbr_pkg.sv
package bbr_pkg;

  // Sequencer view of the cycle it is presenting on the bus
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_BEAT  = 2'd1,
    SQ_ABORT = 2'd2
  } seq_state_e;

  // Beats in one line transfer on the 64-bit bus
  localparam int unsigned LINE_BEATS = 4;

endpackage

// File: rtl/bbr_req_fifo.sv
module bbr_req_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             push_ok, pop_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = slots[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) slots[wr_ptr] <= din;
  end

endmodule

// File: rtl/bbr_beat_seq.sv
module bbr_beat_seq
  import bbr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BEATS  = LINE_BEATS,
  parameter int unsigned BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  logic              head_write,
  input  logic              head_burst,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic              head_abt_en,
  input  logic [BEAT_W-1:0] head_abt_beat,
  output logic              pop,
  output logic              dvalid,
  output logic              abort,
  output logic              beat_write,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_last
);
  seq_state_e        st, st_n;
  logic              c_write, c_burst, c_en;
  logic [ADDR_W-1:0] c_addr;
  logic [BEAT_W-1:0] c_abt, idx;
  logic              last_q;
  logic [ADDR_W-1:0] addr_q;

  logic              more, load, present;
  logic              n_write, n_burst, n_en, n_abort, n_last;
  logic [ADDR_W-1:0] n_addr;
  logic [BEAT_W-1:0] n_abt, n_idx, last_idx, abt_idx;

  always_comb begin
    // Continue a burst only after a normal, non-final beat
    more    = (st == SQ_BEAT) && !last_q;
    // The cycle after an abort beat is always left empty
    load    = (st != SQ_ABORT) && !more && head_valid;
    present = load || more;
    pop     = load;

    n_write = load ? head_write    : c_write;
    n_burst = load ? head_burst    : c_burst;
    n_addr  = load ? head_addr     : c_addr;
    n_en    = load ? head_abt_en   : c_en;
    n_abt   = load ? head_abt_beat : c_abt;
    n_idx   = load ? '0            : idx + 1'b1;

    last_idx = n_burst ? BEAT_W'(BEATS - 1) : '0;
    abt_idx  = (n_abt > last_idx) ? last_idx : n_abt;
    n_abort  = n_en && (n_idx == abt_idx);
    n_last   = (n_idx == last_idx);

    if (!present)     st_n = SQ_IDLE;
    else if (n_abort) st_n = SQ_ABORT;
    else              st_n = SQ_BEAT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      c_write <= 1'b0;
      c_burst <= 1'b0;
      c_addr  <= '0;
      c_en    <= 1'b0;
      c_abt   <= '0;
      idx     <= '0;
      last_q  <= 1'b0;
      addr_q  <= '0;
    end else begin
      st <= st_n;
      if (present) begin
        c_write <= n_write;
        c_burst <= n_burst;
        c_addr  <= n_addr;
        c_en    <= n_en;
        c_abt   <= n_abt;
        idx     <= n_idx;
        last_q  <= n_last;
        addr_q  <= n_addr + ADDR_W'(n_idx);
      end
    end
  end

  assign dvalid     = (st != SQ_IDLE);
  assign abort      = (st == SQ_ABORT);
  assign beat_write = c_write;
  assign beat_addr  = addr_q;
  assign beat_last  = last_q;

endmodule

// File: rtl/bbr_data_pipe.sv
module bbr_data_pipe #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NREG   = 16,
  parameter int unsigned ADDR_W = $clog2(NREG),
  parameter int unsigned LAT    = 2,
  parameter int unsigned CHK_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dvalid,
  input  logic              abort,
  input  logic              beat_write,
  input  logic [ADDR_W-1:0] beat_addr,
  input  logic              beat_last,
  input  logic [DATA_W-1:0] bus_wr_data,
  output logic              rd_drive,
  output logic [DATA_W-1:0] rd_data,
  output logic [CHK_W-1:0]  rd_chk,
  output logic              done,
  output logic              done_aborted
);
  logic              pv  [LAT];
  logic              pa  [LAT];
  logic              pw  [LAT];
  logic              pl  [LAT];
  logic [ADDR_W-1:0] pad [LAT];

  // Delay line: stage LAT-1 is live in the data slot of its beat
  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pv[0] <= 1'b0;
          pa[0] <= 1'b0;
          pw[0] <= 1'b0;
          pl[0] <= 1'b0;
          pad[0] <= '0;
        end else begin
          pv[0] <= dvalid;
          pa[0] <= abort;
          pw[0] <= beat_write;
          pl[0] <= beat_last;
          pad[0] <= beat_addr;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pv[g] <= 1'b0;
          pa[g] <= 1'b0;
          pw[g] <= 1'b0;
          pl[g] <= 1'b0;
          pad[g] <= '0;
        end else begin
          pv[g] <= pv[g-1];
          pa[g] <= pa[g-1];
          pw[g] <= pw[g-1];
          pl[g] <= pl[g-1];
          pad[g] <= pad[g-1];
        end
      end
    end
  end

  logic              tv, ta, tw, tl, good;
  logic [ADDR_W-1:0] tad;
  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] word;
  logic [CHK_W-1:0]  par;

  assign tv  = pv[LAT-1];
  assign ta  = pa[LAT-1];
  assign tw  = pw[LAT-1];
  assign tl  = pl[LAT-1];
  assign tad = pad[LAT-1];

  assign word = regs[tad];

  always_comb begin
    for (int j = 0; j < int'(CHK_W); j++) par[j] = ^word[8*j +: 8];
  end

  assign rd_drive     = tv && !tw;
  assign good         = rd_drive && !ta;
  assign rd_data      = good ? word : '0;
  assign rd_chk       = good ? par  : '0;
  assign done         = tv && (tl || ta);
  assign done_aborted = tv && ta;

  // Aborted write slot carries no data from the bus: skip the capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NREG); i++) regs[i] <= '0;
    end else if (tv && tw && !ta) begin
      regs[tad] <= bus_wr_data;
    end
  end

endmodule

// File: rtl/bus_beat_responder.sv
module bus_beat_responder
  import bbr_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NREG   = 16,
  parameter int unsigned BEATS  = LINE_BEATS,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = $clog2(NREG),
  parameter int unsigned BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  parameter int unsigned CHK_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_abort_en,
  input  logic [BEAT_W-1:0] req_abort_beat,
  output logic              dvalid,
  output logic              abort,
  input  logic [DATA_W-1:0] bus_wr_data,
  output logic              rd_drive,
  output logic [DATA_W-1:0] rd_data,
  output logic [CHK_W-1:0]  rd_chk,
  output logic              done,
  output logic              done_aborted
);
  localparam int unsigned REQ_W = 3 + ADDR_W + BEAT_W;
  localparam int unsigned XFER_LAT = 2;

  logic [REQ_W-1:0]  q_in, q_out;
  logic              q_full, q_empty, q_pop;
  logic              h_write, h_burst, h_en;
  logic [ADDR_W-1:0] h_addr;
  logic [BEAT_W-1:0] h_abt;
  logic              beat_write, beat_last;
  logic [ADDR_W-1:0] beat_addr;

  assign q_in      = {req_write, req_burst, req_addr, req_abort_en, req_abort_beat};
  assign req_ready = !q_full;
  assign {h_write, h_burst, h_addr, h_en, h_abt} = q_out;

  bbr_req_fifo #(.W(REQ_W), .DEPTH(DEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (req_valid),
    .din   (q_in),
    .full  (q_full),
    .pop   (q_pop),
    .dout  (q_out),
    .empty (q_empty)
  );

  bbr_beat_seq #(.ADDR_W(ADDR_W), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .head_valid    (!q_empty),
    .head_write    (h_write),
    .head_burst    (h_burst),
    .head_addr     (h_addr),
    .head_abt_en   (h_en),
    .head_abt_beat (h_abt),
    .pop           (q_pop),
    .dvalid        (dvalid),
    .abort         (abort),
    .beat_write    (beat_write),
    .beat_addr     (beat_addr),
    .beat_last     (beat_last)
  );

  bbr_data_pipe #(
    .DATA_W(DATA_W), .NREG(NREG), .ADDR_W(ADDR_W), .LAT(XFER_LAT), .CHK_W(CHK_W)
  ) u_pipe (
    .clk          (clk),
    .rst_n        (rst_n),
    .dvalid       (dvalid),
    .abort        (abort),
    .beat_write   (beat_write),
    .beat_addr    (beat_addr),
    .beat_last    (beat_last),
    .bus_wr_data  (bus_wr_data),
    .rd_drive     (rd_drive),
    .rd_data      (rd_data),
    .rd_chk       (rd_chk),
    .done         (done),
    .done_aborted (done_aborted)
  );

endmodule

// File: rtl/bbr_checker.sv
module bbr_checker #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CHK_W  = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dvalid,
  input logic              abort,
  input logic              beat_write,
  input logic              rd_drive,
  input logic [DATA_W-1:0] rd_data,
  input logic [CHK_W-1:0]  rd_chk,
  input logic              done,
  input logic              done_aborted
);

  AST_ABORT_NEEDS_DVALID: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> dvalid); // R5

  AST_DEAD_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!dvalid && !abort)); // R7

  AST_READ_SLOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && !beat_write) |=> ##1 rd_drive); // R3

  AST_WRITE_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && beat_write) |=> ##1 !rd_drive); // R4

  AST_ABORTED_READ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !beat_write) |=> ##1 (rd_drive && rd_data == '0 && rd_chk == '0)); // R8

  AST_ABORTED_WRITE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && beat_write) |=> ##1 (done_aborted && !rd_drive)); // R9

  AST_ABORT_FLAG_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_aborted |-> done); // R11

  AST_ABORT_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> ##1 done_aborted); // R11

endmodule

bind bus_beat_responder bbr_checker #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_bbr_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dvalid       (dvalid),
  .abort        (abort),
  .beat_write   (beat_write),
  .rd_drive     (rd_drive),
  .rd_data      (rd_data),
  .rd_chk       (rd_chk),
  .done         (done),
  .done_aborted (done_aborted)
);

// File: tb/tb_bus_beat_responder.sv
`timescale 1ns/1ps
module tb_bus_beat_responder;

  localparam int NREG  = 16;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_burst = 1'b0;
  logic [3:0]  req_addr = '0;
  logic        req_abort_en = 1'b0;
  logic [1:0]  req_abort_beat = '0;
  logic        dvalid, abort;
  logic [63:0] bus_wr_data = '0;
  logic        rd_drive;
  logic [63:0] rd_data;
  logic [7:0]  rd_chk;
  logic        done, done_aborted;

  always #2 clk = ~clk; // 250 MHz

  bus_beat_responder dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
    .req_abort_en(req_abort_en), .req_abort_beat(req_abort_beat),
    .dvalid(dvalid), .abort(abort), .bus_wr_data(bus_wr_data),
    .rd_drive(rd_drive), .rd_data(rd_data), .rd_chk(rd_chk),
    .done(done), .done_aborted(done_aborted)
  );

  typedef struct { bit w; bit b; int a; bit en; int ab; int tag; } tx_t;

  tx_t plan[$];
  tx_t mq[$];
  tx_t cur;
  int  m_st, m_idx, m_addr, h1, h2;
  bit  m_last;
  int  pv[2], pa[2], pw[2], pl[2], pad[2], ptag[2];
  logic [63:0] m_mem [NREG];
  int  n_chk = 0, n_fail = 0, cyc = 0;
  bit  finished = 1'b0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic add(input bit w, input bit b, input int a, input bit en, input int ab, input int tag);
    tx_t t;
    t.w = w; t.b = b; t.a = a; t.en = en; t.ab = ab; t.tag = tag;
    plan.push_back(t);
  endtask

  function automatic logic [7:0] parity8(input logic [63:0] v);
    logic [7:0] p;
    for (int j = 0; j < 8; j++) p[j] = ^v[8*j +: 8];
    return p;
  endfunction

  task automatic model_reset();
    mq.delete();
    m_st = 0; m_idx = 0; m_addr = 0; m_last = 0; h1 = 0; h2 = 0;
    cur = '{0, 0, 0, 0, 0, 3};
    for (int i = 0; i < 2; i++) begin
      pv[i] = 0; pa[i] = 0; pw[i] = 0; pl[i] = 0; pad[i] = 0; ptag[i] = 3;
    end
    for (int i = 0; i < NREG; i++) m_mem[i] = '0;
  endtask

  // One clock edge of the reference behaviour
  task automatic model_step(input bit acc, input tx_t in_tx, input logic [63:0] wd);
    bit more, load;
    int last_i, ai;
    if (pv[1] != 0 && pw[1] != 0 && pa[1] == 0) m_mem[pad[1]] = wd;
    pv[1] = pv[0]; pa[1] = pa[0]; pw[1] = pw[0]; pl[1] = pl[0]; pad[1] = pad[0]; ptag[1] = ptag[0];
    pv[0] = (m_st != 0); pa[0] = (m_st == 2); pw[0] = cur.w; pl[0] = m_last;
    pad[0] = m_addr; ptag[0] = cur.tag;
    h2 = h1; h1 = m_st;
    more = (m_st == 1) && !m_last;
    load = (m_st != 2) && !more && (mq.size() > 0);
    if (load) begin
      cur = mq.pop_front();
      m_idx = 0;
    end else if (more) begin
      m_idx++;
    end
    if (load || more) begin
      last_i = cur.b ? 3 : 0;
      ai = (cur.ab > last_i) ? last_i : cur.ab;
      m_last = (m_idx == last_i);
      m_addr = (cur.a + m_idx) % NREG;
      m_st = (cur.en && m_idx == ai) ? 2 : 1;
    end else begin
      m_st = 0;
    end
    if (acc) mq.push_back(in_tx);
  endtask

  task automatic compare_all();
    string dtag;
    logic [63:0] ed;
    bit drv;
    if (h1 == 2) dtag = "R7";
    else if (h2 == 2) dtag = "R6";
    else dtag = "R2";
    chk(dtag, "dvalid", 64'(dvalid), 64'(m_st != 0));
    chk("R5", "abort", 64'(abort), 64'(m_st == 2));
    chk("R10", "req_ready", 64'(req_ready), 64'(mq.size() < DEPTH));
    drv = (pv[1] != 0) && (pw[1] == 0);
    chk("R3", "rd_drive", 64'(rd_drive), 64'(drv));
    ed = (drv && pa[1] == 0) ? m_mem[pad[1]] : 64'd0;
    if (drv && pa[1] != 0) dtag = "R8";
    else dtag = $sformatf("R%0d", ptag[1]);
    chk(dtag, "rd_data", rd_data, ed);
    chk(dtag, "rd_chk", 64'(rd_chk), 64'((drv && pa[1] == 0) ? parity8(ed) : 8'd0));
    chk("R11", "done", 64'(done), 64'(pv[1] != 0 && (pl[1] != 0 || pa[1] != 0)));
    chk("R11", "done_aborted", 64'(done_aborted), 64'(pv[1] != 0 && pa[1] != 0));
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int pi;
    int seed;
    bit gap, acc;
    tx_t t;
    model_reset();
    // R4: plain writes, then a write burst
    for (int i = 0; i < 8; i++) add(1, 0, i, 0, 0, 4);
    add(1, 1, 8, 0, 0, 4);
    // R3/R2: single reads, a burst read, a wrapping burst read
    for (int i = 0; i < 4; i++) add(0, 0, i, 0, 0, 3);
    add(0, 1, 8, 0, 0, 3);
    add(0, 1, 14, 0, 0, 3);
    // R8/R6: burst read aborted on beat 2, followed at once by another read
    add(0, 1, 4, 1, 2, 3);
    add(0, 0, 9, 0, 0, 3);
    // R9: burst write aborted on beat 1, read the line back
    add(1, 1, 12, 1, 1, 9);
    add(0, 1, 12, 0, 0, 9);
    // R5: abort on the first beat of a burst; clipped abort beat on a single
    add(0, 1, 0, 1, 0, 3);
    add(0, 0, 3, 1, 3, 3);
    add(1, 0, 5, 1, 0, 9);
    add(0, 0, 5, 0, 0, 9);
    // R10: mixed traffic from a simple generator
    seed = 32'h1234_5677;
    for (int i = 0; i < 60; i++) begin
      seed = seed * 1103515245 + 12345;
      add(seed[16], seed[17], seed[23:20], seed[26:24] == 3'd0, int'(seed[29:28]), 3);
    end
    // R4/R9: final read-back of every register
    for (int i = 0; i < NREG; i++) add(0, 0, i, 0, 0, 4);

    // R1: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "dvalid", 64'(dvalid), 64'd0);
    chk("R1", "abort", 64'(abort), 64'd0);
    chk("R1", "rd_drive", 64'(rd_drive), 64'd0);
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "done_aborted", 64'(done_aborted), 64'd0);
    chk("R1", "req_ready", 64'(req_ready), 64'd1);
    rst_n = 1'b1;

    pi = 0;
    while (pi < plan.size() || mq.size() > 0 || m_st != 0 || pv[0] != 0 || pv[1] != 0) begin
      @(negedge clk);
      cyc++;
      compare_all();
      bus_wr_data = {32'(cyc) * 32'h9E37_79B1, ~32'(cyc)};
      gap = (cyc % 9 == 4) && (pi > 20);
      if (pi < plan.size() && !gap) begin
        t = plan[pi];
        req_valid = 1'b1;
        req_write = t.w; req_burst = t.b; req_addr = 4'(t.a);
        req_abort_en = t.en; req_abort_beat = 2'(t.ab);
      end else begin
        req_valid = 1'b0;
      end
      @(posedge clk);
      acc = req_valid && (mq.size() < DEPTH);
      model_step(acc, t, bus_wr_data);
      if (acc) pi++;
    end
    repeat (3) begin
      @(negedge clk);
      cyc++;
      compare_all();
      @(posedge clk);
      model_step(1'b0, t, bus_wr_data);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule